// File: doc/BRIEF.md
# Data-Space Access Controller with Region Wait States

This block stands between a single bus master and a unified 16-bit, byte-addressed data space. It sorts each address into one of four regions: I/O registers, a memory-mapped window onto nonvolatile storage, internal SRAM, and reserved space. It then holds the access for a fixed number of cycles. That number depends on the region and on whether the access is a read or a write. The master gets a one-cycle ready pulse, and read data in the same cycle.

The master presents a request and holds the address and control signals steady until it sees `rsp_ready`. Only one access is outstanding at a time. A new request may be driven in the cycle that follows the ready pulse.

Reads can be chained into a burst by holding `req_burst` high. After the first read of a burst, each further read to the same region uses that region's burst throughput. A burst ends when `req_burst` is dropped or when an access goes to a different region. The I/O register file, the storage window and the SRAM are all held inside the block.

The I/O register file is bit-addressable over its lowest 32 addresses. Only the low `IO_REGS` I/O addresses are backed, and higher I/O addresses alias onto them modulo `IO_REGS`.

Top module: `dspace_wait_ctrl`

## Requirements
- R1: With default parameters the regions decode as follows:
  - 0x0000–0x0FFF is I/O.
  - 0x1000–0x17FF is the storage window.
  - 0x2000–0x2FFF is SRAM.
  - Every other address is reserved.
- R2: The latency L of an access is the number of rising edges from the edge that first samples `req_valid` high up to and including the edge after which `rsp_ready` is high. `rsp_ready` stays high for one cycle. I/O reads and writes have L = 1.
- R3: An SRAM write has L = 1. A single SRAM read, or the first read of a burst, has L = 2.
- R4: A write to the storage window has L = 1. A single read from it, or the first read of a burst, has L = 3.
- R5: A burst read that continues in the same region as the previous burst read has L = 1 in SRAM and L = 2 in the storage window.
- R6: An access with `req_burst` low ends a burst, and so does an access to a different region. The next read then pays the full latency of its region, even if `req_burst` is high again.
- R7: An access to a reserved address completes with L = 1. A write there changes nothing. A read there returns 0x00. `rsp_err` is high only in that access's ready cycle.
- R8: `req_op` is encoded as 0 = byte access, 1 = set bit, 2 = clear bit and 3 = test bit. `req_bit` selects bit 0–7. These operations are allowed on I/O addresses 0x00–0x1F and have L = 1:
  - Set and clear change only the selected bit.
  - Test changes nothing and returns 0x01 or 0x00.
- R9: A bit operation outside I/O addresses 0x00–0x1F is rejected. It completes with L = 1, `rsp_err` high and data 0x00, and the target byte is left unchanged.
- R10: During and right after reset, `rsp_ready` and `rsp_err` are low, and every I/O register reads 0x00.
- R11: A read returns the last byte written to that address in its region. A write or a set/clear acknowledge returns data 0x00 with `rsp_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `rsp_ready` |
| req_write | input | 1 | 1 = write, 0 = read (byte accesses only) |
| req_burst | input | 1 | Burst read request |
| req_op | input | 2 | 0 byte, 1 set bit, 2 clear bit, 3 test bit |
| req_bit | input | 3 | Bit index for bit operations |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_ready` |
| rsp_err | output | 1 | Access rejected, valid with `rsp_ready` |

## Verification
The region decode is tried with addresses on both edges of each window, such as 0x0FFF, 0x1000, 0x17FF, 0x1800, 0x2FFF and 0x3000. The measured latency and the error flag show which region each address landed in.

Back-to-back reads and writes with no idle cycles separate the write and read latencies of every region. Chained burst reads, with the burst flag dropped and raised again and with a jump from one region to another, separate the first-read latency from the continuation throughput.

Bit set, clear and test on legal and illegal addresses, each followed by a plain read of the target byte, show that the selected bit alone moved or that nothing moved.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [1:0] {
    RG_IO   = 2'd0,
    RG_NV   = 2'd1,
    RG_RSVD = 2'd2,
    RG_SRAM = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    OP_BYTE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TEST = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_IO   = 3'd1,
    SRC_NV   = 3'd2,
    SRC_SRAM = 3'd3,
    SRC_BIT  = 3'd4
  } src_e;
endpackage

// File: rtl/dsw_decode.sv
// Address-to-region decoder. Window bases must be aligned to window sizes.
module dsw_decode
  import dsw_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned IO_SPAN    = 4096,
  parameter int unsigned NV_BASE    = 4096,
  parameter int unsigned NV_BYTES   = 2048,
  parameter int unsigned SRAM_BASE  = 8192,
  parameter int unsigned SRAM_BYTES = 4096,
  parameter int unsigned BIT_SPAN   = 32
) (
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic          bit_ok
);
  localparam int unsigned NV_END   = NV_BASE + NV_BYTES;
  localparam int unsigned SRAM_END = SRAM_BASE + SRAM_BYTES;

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    if (a32 < IO_SPAN) begin
      region = RG_IO;
    end else if (a32 >= NV_BASE && a32 < NV_END) begin
      region = RG_NV;
    end else if (a32 >= SRAM_BASE && a32 < SRAM_END) begin
      region = RG_SRAM;
    end else begin
      region = RG_RSVD;
    end
  end

  assign bit_ok = (a32 < BIT_SPAN);
endmodule

// File: rtl/dsw_sync_ram.sv
// Single-port byte memory with registered read, written for block RAM inference.
module dsw_sync_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        q <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/dsw_io_file.sv
// I/O register file with byte access and single-bit set, clear and test.
module dsw_io_file
  import dsw_pkg::*;
#(
  parameter int DW   = 8,
  parameter int REGS = 64,
  parameter int IW   = $clog2(REGS),
  parameter int BW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          we,
  input  op_e           op,
  input  logic [IW-1:0] idx,
  input  logic [BW-1:0] bsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_q,
  output logic          bit_q
);
  logic [DW-1:0] regs [REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS; i++) begin
        regs[i] <= '0;
      end
      rd_q  <= '0;
      bit_q <= 1'b0;
    end else if (acc) begin
      case (op)
        OP_BYTE: begin
          if (we) begin
            regs[idx] <= wdata;
          end else begin
            rd_q <= regs[idx];
          end
        end
        OP_SET:  regs[idx][bsel] <= 1'b1;
        OP_CLR:  regs[idx][bsel] <= 1'b0;
        default: bit_q <= regs[idx][bsel];
      endcase
    end
  end

  AST_SETCLR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    acc && (op == OP_SET || op == OP_CLR) |=>
      $countones(regs[$past(idx)] ^ $past(regs[idx])) <= 1); // R8
  AST_TEST_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    acc && op == OP_TEST |=> regs[$past(idx)] == $past(regs[idx])); // R8
endmodule

// File: rtl/dsw_timer.sv
// Wait-state counter, ready pulse and burst continuation tracker.
module dsw_timer
  import dsw_pkg::*;
#(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_burst,
  input  logic          burstable,
  input  region_e       region,
  input  logic [LW-1:0] lat_full,
  input  logic [LW-1:0] lat_burst,
  output logic          acc,
  output logic          rdy
);
  logic          busy;
  logic [LW-1:0] cnt;
  logic          burst_live;
  region_e       burst_rg;
  logic          cont;
  logic [LW-1:0] lat_sel;

  assign acc     = req_valid && !busy;
  assign cont    = burst_live && burstable && req_burst && (region == burst_rg);
  assign lat_sel = cont ? lat_burst : lat_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cnt        <= '0;
      rdy        <= 1'b0;
      burst_live <= 1'b0;
      burst_rg   <= RG_IO;
    end else begin
      rdy <= 1'b0;
      if (acc) begin
        burst_live <= burstable && req_burst;
        burst_rg   <= region;
        if (lat_sel <= LW'(1)) begin
          rdy <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= lat_sel - LW'(1);
        end
      end else if (busy) begin
        cnt <= cnt - LW'(1);
        if (cnt == LW'(1)) begin
          busy <= 1'b0;
          rdy  <= 1'b1;
        end
      end else if (!req_burst) begin
        burst_live <= 1'b0;
      end
    end
  end

  AST_LAT_ONE: assert property (@(posedge clk) disable iff (rst)
    acc && lat_sel == LW'(1) |=> rdy); // R2
  AST_LAT_TWO: assert property (@(posedge clk) disable iff (rst)
    acc && lat_sel == LW'(2) |=> !rdy ##1 rdy); // R3
  AST_LAT_THREE: assert property (@(posedge clk) disable iff (rst)
    acc && lat_sel == LW'(3) |=> !rdy ##1 !rdy ##1 rdy); // R4
  AST_NO_ACCEPT_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    acc && lat_sel > LW'(1) |=> !acc); // R6
endmodule

// File: rtl/dspace_wait_ctrl.sv
// Data-space access controller: region decode, per-region wait states, burst reads.
module dspace_wait_ctrl
  import dsw_pkg::*;
#(
  parameter int unsigned IO_SPAN        = 4096,
  parameter int unsigned IO_REGS        = 64,
  parameter int unsigned BIT_SPAN       = 32,
  parameter int unsigned NV_BASE        = 4096,
  parameter int unsigned NV_BYTES       = 2048,
  parameter int unsigned SRAM_BASE      = 8192,
  parameter int unsigned SRAM_BYTES     = 4096,
  parameter int unsigned LAT_IO         = 1,
  parameter int unsigned LAT_NV_RD      = 3,
  parameter int unsigned LAT_NV_WR      = 1,
  parameter int unsigned LAT_NV_BURST   = 2,
  parameter int unsigned LAT_SRAM_RD    = 2,
  parameter int unsigned LAT_SRAM_WR    = 1,
  parameter int unsigned LAT_SRAM_BURST = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_burst,
  input  logic [1:0]  req_op,
  input  logic [2:0]  req_bit,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_ready,
  output logic [7:0]  rsp_rdata,
  output logic        rsp_err
);
  localparam int AW      = 16;
  localparam int DW      = 8;
  localparam int NV_AW   = $clog2(NV_BYTES);
  localparam int SRAM_AW = $clog2(SRAM_BYTES);
  localparam int IO_IW   = $clog2(IO_REGS);
  localparam int BW      = $clog2(DW);
  localparam int unsigned M1 = (LAT_NV_RD > LAT_SRAM_RD) ? LAT_NV_RD : LAT_SRAM_RD;
  localparam int unsigned M2 = (LAT_NV_WR > LAT_SRAM_WR) ? LAT_NV_WR : LAT_SRAM_WR;
  localparam int unsigned M3 = (LAT_NV_BURST > LAT_SRAM_BURST) ? LAT_NV_BURST : LAT_SRAM_BURST;
  localparam int unsigned M4 = (M1 > M2) ? M1 : M2;
  localparam int unsigned M5 = (M3 > LAT_IO) ? M3 : LAT_IO;
  localparam int unsigned LAT_MAX = (M4 > M5) ? M4 : M5;
  localparam int LW = $clog2(LAT_MAX + 1);

  region_e       region;
  logic          bit_ok;
  op_e           op;
  logic          is_bitop;
  logic          bad;
  logic          burstable;
  logic          mem_we;
  logic [LW-1:0] lat_full;
  logic [LW-1:0] lat_burst;
  logic          acc;
  logic          rdy;
  logic          io_acc;
  logic          nv_en;
  logic          sram_en;
  logic [DW-1:0] io_q;
  logic          bit_q;
  logic [DW-1:0] nv_q;
  logic [DW-1:0] sram_q;
  src_e          src_q;
  logic          err_q;

  dsw_decode #(
    .AW(AW), .IO_SPAN(IO_SPAN), .NV_BASE(NV_BASE), .NV_BYTES(NV_BYTES),
    .SRAM_BASE(SRAM_BASE), .SRAM_BYTES(SRAM_BYTES), .BIT_SPAN(BIT_SPAN)
  ) u_decode (
    .addr(req_addr), .region(region), .bit_ok(bit_ok)
  );

  assign op        = op_e'(req_op);
  assign is_bitop  = (op != OP_BYTE);
  assign bad       = (region == RG_RSVD) || (is_bitop && !(region == RG_IO && bit_ok));
  assign burstable = !req_write && !is_bitop && (region == RG_NV || region == RG_SRAM);
  assign mem_we    = req_write && !is_bitop;

  always_comb begin
    lat_full = LW'(1);
    if (!bad) begin
      case (region)
        RG_IO:   lat_full = LW'(LAT_IO);
        RG_NV:   lat_full = mem_we ? LW'(LAT_NV_WR) : LW'(LAT_NV_RD);
        RG_SRAM: lat_full = mem_we ? LW'(LAT_SRAM_WR) : LW'(LAT_SRAM_RD);
        default: lat_full = LW'(1);
      endcase
    end
  end

  always_comb begin
    case (region)
      RG_NV:   lat_burst = LW'(LAT_NV_BURST);
      RG_SRAM: lat_burst = LW'(LAT_SRAM_BURST);
      default: lat_burst = lat_full;
    endcase
  end

  dsw_timer #(.LW(LW)) u_timer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_burst(req_burst),
    .burstable(burstable), .region(region), .lat_full(lat_full),
    .lat_burst(lat_burst), .acc(acc), .rdy(rdy)
  );

  assign io_acc  = acc && !bad && (region == RG_IO);
  assign nv_en   = acc && !bad && (region == RG_NV);
  assign sram_en = acc && !bad && (region == RG_SRAM);

  dsw_io_file #(.DW(DW), .REGS(IO_REGS)) u_io (
    .clk(clk), .rst(rst), .acc(io_acc), .we(req_write), .op(op),
    .idx(req_addr[IO_IW-1:0]), .bsel(req_bit[BW-1:0]), .wdata(req_wdata),
    .rd_q(io_q), .bit_q(bit_q)
  );

  dsw_sync_ram #(.DW(DW), .DEPTH(NV_BYTES)) u_nv (
    .clk(clk), .en(nv_en), .we(mem_we), .addr(req_addr[NV_AW-1:0]),
    .wdata(req_wdata), .q(nv_q)
  );

  dsw_sync_ram #(.DW(DW), .DEPTH(SRAM_BYTES)) u_sram (
    .clk(clk), .en(sram_en), .we(mem_we), .addr(req_addr[SRAM_AW-1:0]),
    .wdata(req_wdata), .q(sram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_ZERO;
      err_q <= 1'b0;
    end else begin
      err_q <= acc && bad;
      if (acc) begin
        if (bad || mem_we || op == OP_SET || op == OP_CLR) begin
          src_q <= SRC_ZERO;
        end else if (op == OP_TEST) begin
          src_q <= SRC_BIT;
        end else begin
          case (region)
            RG_IO:   src_q <= SRC_IO;
            RG_NV:   src_q <= SRC_NV;
            RG_SRAM: src_q <= SRC_SRAM;
            default: src_q <= SRC_ZERO;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_IO:   rsp_rdata = io_q;
      SRC_NV:   rsp_rdata = nv_q;
      SRC_SRAM: rsp_rdata = sram_q;
      SRC_BIT:  rsp_rdata = {{(DW-1){1'b0}}, bit_q};
      default:  rsp_rdata = '0;
    endcase
  end

  assign rsp_ready = rdy;
  assign rsp_err   = err_q;

  AST_ERR_IN_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_ready); // R7
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == '0); // R9
  AST_BITOP_REJECT: assert property (@(posedge clk) disable iff (rst)
    acc && is_bitop && (region != RG_IO || !bit_ok) |=> rsp_err && rsp_ready); // R9
  AST_RSVD_FAST: assert property (@(posedge clk) disable iff (rst)
    acc && region == RG_RSVD |=> rsp_ready && rsp_err); // R7
endmodule

// File: tb/dspace_wait_ctrl_bench.sv
module dspace_wait_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [2:0]  req_bit = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        rsp_ready;
  logic [7:0]  rsp_rdata;
  logic        rsp_err;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dspace_wait_ctrl u_dspace_wait_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_op(req_op), .req_bit(req_bit),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  // Fields: addr[44:29] wr[28] op[27:26] bit[25:23] wdata[22:15]
  //         lat[14:13] rdata[12:5] err[4] req[3:0]
  localparam logic [44:0] VEC [NVEC] = '{
    {16'h0005, 1'b1, 2'd0, 3'd0, 8'hA5, 2'd1, 8'h00, 1'b0, 4'd2},  // R2 io write
    {16'h0005, 1'b0, 2'd0, 3'd0, 8'h00, 2'd1, 8'hA5, 1'b0, 4'd2},  // R2 io read
    {16'h2000, 1'b1, 2'd0, 3'd0, 8'h11, 2'd1, 8'h00, 1'b0, 4'd3},  // R3 sram write
    {16'h2001, 1'b1, 2'd0, 3'd0, 8'h22, 2'd1, 8'h00, 1'b0, 4'd3},  // R3
    {16'h2002, 1'b1, 2'd0, 3'd0, 8'h33, 2'd1, 8'h00, 1'b0, 4'd11}, // R11
    {16'h2FFF, 1'b1, 2'd0, 3'd0, 8'h44, 2'd1, 8'h00, 1'b0, 4'd1},  // R1 sram top
    {16'h2FFF, 1'b0, 2'd0, 3'd0, 8'h00, 2'd2, 8'h44, 1'b0, 4'd3},  // R3 sram read
    {16'h1000, 1'b1, 2'd0, 3'd0, 8'h55, 2'd1, 8'h00, 1'b0, 4'd4},  // R4 nv write
    {16'h1001, 1'b1, 2'd0, 3'd0, 8'h66, 2'd1, 8'h00, 1'b0, 4'd4},  // R4
    {16'h17FF, 1'b1, 2'd0, 3'd0, 8'h77, 2'd1, 8'h00, 1'b0, 4'd1},  // R1 nv top
    {16'h17FF, 1'b0, 2'd0, 3'd0, 8'h00, 2'd3, 8'h77, 1'b0, 4'd4},  // R4 nv read
    {16'h1800, 1'b1, 2'd0, 3'd0, 8'h99, 2'd1, 8'h00, 1'b1, 4'd7},  // R7 rsvd write
    {16'h1800, 1'b0, 2'd0, 3'd0, 8'h00, 2'd1, 8'h00, 1'b1, 4'd7},  // R7 rsvd read
    {16'h3000, 1'b0, 2'd0, 3'd0, 8'h00, 2'd1, 8'h00, 1'b1, 4'd1},  // R1 above sram
    {16'h0FFF, 1'b0, 2'd0, 3'd0, 8'h00, 2'd1, 8'h00, 1'b0, 4'd1},  // R1 io top
    {16'h0003, 1'b0, 2'd1, 3'd6, 8'h00, 2'd1, 8'h00, 1'b0, 4'd8},  // R8 set
    {16'h0003, 1'b0, 2'd0, 3'd0, 8'h00, 2'd1, 8'h40, 1'b0, 4'd8},  // R8
    {16'h0003, 1'b0, 2'd3, 3'd6, 8'h00, 2'd1, 8'h01, 1'b0, 4'd8},  // R8 test one
    {16'h0003, 1'b0, 2'd3, 3'd5, 8'h00, 2'd1, 8'h00, 1'b0, 4'd8},  // R8 test zero
    {16'h001F, 1'b0, 2'd1, 3'd0, 8'h00, 2'd1, 8'h00, 1'b0, 4'd8},  // R8 edge 0x1F
    {16'h0005, 1'b0, 2'd2, 3'd0, 8'h00, 2'd1, 8'h00, 1'b0, 4'd8},  // R8 clear
    {16'h0005, 1'b0, 2'd0, 3'd0, 8'h00, 2'd1, 8'hA4, 1'b0, 4'd8},  // R8
    {16'h0020, 1'b0, 2'd1, 3'd0, 8'h00, 2'd1, 8'h00, 1'b1, 4'd9},  // R9 set at 0x20
    {16'h0020, 1'b0, 2'd0, 3'd0, 8'h00, 2'd1, 8'h00, 1'b0, 4'd9},  // R9 unchanged
    {16'h2000, 1'b0, 2'd1, 3'd1, 8'h00, 2'd1, 8'h00, 1'b1, 4'd9},  // R9 set in sram
    {16'h2000, 1'b0, 2'd0, 3'd0, 8'h00, 2'd2, 8'h11, 1'b0, 4'd9}   // R9 unchanged
  };

  task automatic check(input int rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] a, input logic w, input logic [1:0] op,
                     input logic [2:0] b, input logic [7:0] d, input logic bu,
                     input int elat, input logic [7:0] erd, input logic eerr,
                     input int rq);
    int n;
    n = 0;
    req_valid = 1'b1;
    req_addr  = a;
    req_write = w;
    req_op    = op;
    req_bit   = b;
    req_wdata = d;
    req_burst = bu;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!rsp_ready && n < 10);
    check(rq, "latency", n, elat);
    check(rq, "rdata", int'(rsp_rdata), int'(erd));
    check(rq, "err", int'(rsp_err), int'(eerr));
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(10, "ready in reset", int'(rsp_ready), 0);  // R10
    check(10, "err in reset", int'(rsp_err), 0);      // R10
    rst = 1'b0;
    run(16'h0010, 1'b0, 2'd0, 3'd0, 8'h00, 1'b0, 1, 8'h00, 1'b0, 10); // R10 io reset value

    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i][44:29], VEC[i][28], VEC[i][27:26], VEC[i][25:23], VEC[i][22:15],
          1'b0, int'(VEC[i][14:13]), VEC[i][12:5], VEC[i][4], int'(VEC[i][3:0]));
    end

    // R5: SRAM burst continues at one cycle per byte
    run(16'h2000, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 2, 8'h11, 1'b0, 5);
    run(16'h2001, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 1, 8'h22, 1'b0, 5);
    run(16'h2002, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 1, 8'h33, 1'b0, 5);
    // R6: burst dropped, then restarted pays full latency
    run(16'h2000, 1'b0, 2'd0, 3'd0, 8'h00, 1'b0, 2, 8'h11, 1'b0, 6);
    run(16'h2001, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 2, 8'h22, 1'b0, 6);
    run(16'h2002, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 1, 8'h33, 1'b0, 5);
    // R6: crossing into the storage window starts fresh
    run(16'h1000, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 3, 8'h55, 1'b0, 6);
    run(16'h1001, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 2, 8'h66, 1'b0, 5);
    // R6: crossing back into SRAM starts fresh
    run(16'h2000, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 2, 8'h11, 1'b0, 6);
    req_burst = 1'b0;

    // R10: reset mid-run clears the I/O file and the handshake
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(10, "ready after reset", int'(rsp_ready), 0);
    check(10, "err after reset", int'(rsp_err), 0);
    rst = 1'b0;
    run(16'h0005, 1'b0, 2'd0, 3'd0, 8'h00, 1'b0, 1, 8'h00, 1'b0, 10); // R10

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule